// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the byte-wide write bus of a parallel flash array and turns unlock-style command sequences into single-cycle action strobes. Each bus write passes through a synchronizer and a pulse-width filter, so that a write only counts when chip select and write enable are both low, output enable is high, and that state lasts for a minimum number of clock cycles. The accepted writes are then matched against a sequence machine. A two-write unlock prefix comes first. After the prefix, one of three paths follows: a program path, a double-unlock erase path, or an identification entry.

The block tracks whether reads return array data or identification data. In identification mode it answers reads with the manufacturer code, the device code, or the boot-block lockout status. It drops every write that completes while the embedded operation engine reports busy. It also suppresses program and block-erase requests that target the boot block while the lockout flag is set.

The strobes are valid-only pulses and have no ready signal. Each strobe is raised for exactly one clock, and the consumer must take it in that cycle. `cmd_addr` and `cmd_data` hold the payload of the most recent accepted program or block erase command.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A command starts with data AAh written to address 555h, followed by 55h written to 2AAh. Only the low 11 address bits are compared, so 1555h counts as 555h and 3A2AAh counts as 2AAh.
- R2: After the unlock prefix, a third write of A0h to 555h arms the program path. The next write then raises `prog_stb` for one cycle, with `cmd_addr` and `cmd_data` equal to the address and data of that write, whatever the data value is.
- R3: After the unlock prefix, the erase path is 80h to 555h, then AAh to 555h, then 55h to 2AAh. The final write selects the action: 10h to 555h raises `chip_erase_stb`, 30h to any address raises `block_erase_stb` with `cmd_addr` set to that address, and 40h to 555h raises `lockout_stb`.
- R4: After the unlock prefix, 90h to 555h raises `id_enter_stb` and sets `id_mode`. A write of F0h to any address, in any state except while the program path is waiting for its data, raises `id_exit_stb` and clears `id_mode`.
- R5: A lockout command also sets `id_mode`, so array reads only resume after an exit write.
- R6: While `id_mode` is 0, `rd_data` equals `array_rdata`. While `id_mode` is 1, `rd_data` is selected by `rd_addr[1:0]` as follows:
  - 00 reads 9Dh.
  - 01 reads 1Dh when `BOOT_TOP`=1 and 2Dh when `BOOT_TOP`=0.
  - 10, inside the boot block, reads `{7'b0, boot_locked}`.
  - Any other case reads 00h.
- R7: A write that does not match the expected next step returns the machine to idle and raises no strobe. For example, AAh at 555h followed by 56h at 2AAh leaves the machine idle, so a following A0h or data write does nothing.
- R8: A write that completes while `op_busy` is 1 is ignored. It raises no strobe and leaves the sequence position unchanged.
- R9: A write cycle is accepted only if the synchronized `bus_ce_n`=0, `bus_we_n`=0 and `bus_oe_n`=1 hold for at least `MIN_PULSE` consecutive cycles (4 by default). The address is taken from the first cycle of the write and the data from the last. Shorter pulses, and pulses made while `bus_oe_n` is 0, are discarded.
- R10: While `boot_locked` is 1, a program or block erase whose address lies in the boot block raises no strobe. The boot block is the region where `addr[17:14]` is 1111b if `BOOT_TOP`=1, or 0000b if `BOOT_TOP`=0.
- R11: After reset every strobe is 0, `id_mode` is 0 and the machine is idle. Each accepted command raises exactly one strobe for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Bus chip select, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Bus write data |
| op_busy | input | 1 | Embedded operation in progress |
| boot_locked | input | 1 | Boot-block lockout flag |
| rd_addr | input | ADDR_W | Read address |
| array_rdata | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data after the mode mux |
| id_mode | output | 1 | 1 while in identification mode |
| prog_stb | output | 1 | Program request pulse |
| chip_erase_stb | output | 1 | Chip erase request pulse |
| block_erase_stb | output | 1 | Block erase request pulse |
| lockout_stb | output | 1 | Boot lockout enable pulse |
| id_enter_stb | output | 1 | Identification entry pulse |
| id_exit_stb | output | 1 | Identification exit pulse |
| cmd_addr | output | ADDR_W | Address payload of program or block erase |
| cmd_data | output | 8 | Data payload of program |

## Verification
A table of write vectors walks the decoder through each complete command path. The same table also covers prefixes broken by a wrong data byte and prefixes that only match on the low 11 address bits, which separates a real 11-bit compare from a full-width compare. Directed patterns cover several boundary cases:
- A 3-cycle pulse is rejected and a 4-cycle pulse accepted, which checks the filter threshold.
- A busy window in the middle of a sequence must keep the armed state, which separates "ignore" from "reset to idle".
- F0h given as program data must program rather than exit.
- Program and erase attempts inside and outside the boot block, with the lock on and off, exercise the protection gate.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DW = 8;

  localparam logic [DW-1:0] CODE_MFR     = 8'h9D;
  localparam logic [DW-1:0] CODE_DEV_TOP = 8'h1D;
  localparam logic [DW-1:0] CODE_DEV_BOT = 8'h2D;

  localparam logic [DW-1:0] OP_UNLOCK_A = 8'hAA;
  localparam logic [DW-1:0] OP_UNLOCK_B = 8'h55;
  localparam logic [DW-1:0] OP_PROGRAM  = 8'hA0;
  localparam logic [DW-1:0] OP_ERASE    = 8'h80;
  localparam logic [DW-1:0] OP_CHIP     = 8'h10;
  localparam logic [DW-1:0] OP_BLOCK    = 8'h30;
  localparam logic [DW-1:0] OP_LOCK     = 8'h40;
  localparam logic [DW-1:0] OP_ID_ENTER = 8'h90;
  localparam logic [DW-1:0] OP_ID_EXIT  = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PGM,
    ST_ER3,
    ST_ER4,
    ST_ER5
  } seq_st_t;
endpackage

// File: rtl/fcd_bus_filter.sv
module fcd_bus_filter
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic              evt_valid,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [DW-1:0]     evt_data
);
  localparam int PW    = 3 + ADDR_W + DW;
  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);
  localparam logic [PW-1:0]    RSTV    = {3'b111, {(PW-3){1'b0}}};

  logic [SYNC_STAGES-1:0][PW-1:0] pipe;
  logic [PW-1:0] pin;
  logic [PW-1:0] last;

  assign pin = {ce_n, we_n, oe_n, addr, wdata};

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {SYNC_STAGES{RSTV}};
        else        pipe[0] <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {SYNC_STAGES{RSTV}};
        else        pipe <= {pipe[SYNC_STAGES-2:0], pin};
      end
    end
  endgenerate

  assign last = pipe[SYNC_STAGES-1];

  logic              s_ce_n, s_we_n, s_oe_n, active, act_q;
  logic [ADDR_W-1:0] s_addr, a_cap;
  logic [DW-1:0]     s_data, d_cap;
  logic [CNT_W-1:0]  cnt;

  assign {s_ce_n, s_we_n, s_oe_n, s_addr, s_data} = last;
  assign active = !s_ce_n && !s_we_n && s_oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      cnt       <= '0;
      a_cap     <= '0;
      d_cap     <= '0;
      evt_valid <= 1'b0;
      evt_addr  <= '0;
      evt_data  <= '0;
    end else begin
      act_q     <= active;
      evt_valid <= 1'b0;
      if (active && !act_q) begin
        a_cap <= s_addr;
        d_cap <= s_data;
        cnt   <= CNT_W'(1);
      end else if (active) begin
        d_cap <= s_data;
        if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      end
      if (!active && act_q && cnt == CNT_MAX) begin
        evt_valid <= 1'b1;
        evt_addr  <= a_cap;
        evt_data  <= d_cap;
      end
    end
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int CMP_W    = 11,
  parameter int BOOT_W   = 4,
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [DW-1:0]     evt_data,
  input  logic              op_busy,
  input  logic              boot_locked,
  output logic              id_mode,
  output logic              prog_stb,
  output logic              chip_erase_stb,
  output logic              block_erase_stb,
  output logic              lockout_stb,
  output logic              id_enter_stb,
  output logic              id_exit_stb,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DW-1:0]     cmd_data
);
  localparam logic [CMP_W-1:0] KEY_A = CMP_W'('h555);
  localparam logic [CMP_W-1:0] KEY_B = CMP_W'('h2AA);

  seq_st_t st;
  logic    at_a, at_b, in_boot, guard;

  assign at_a    = evt_addr[CMP_W-1:0] == KEY_A;
  assign at_b    = evt_addr[CMP_W-1:0] == KEY_B;
  assign in_boot = BOOT_TOP ? (&evt_addr[ADDR_W-1 -: BOOT_W])
                            : (~|evt_addr[ADDR_W-1 -: BOOT_W]);
  assign guard   = boot_locked && in_boot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st              <= ST_IDLE;
      id_mode         <= 1'b0;
      prog_stb        <= 1'b0;
      chip_erase_stb  <= 1'b0;
      block_erase_stb <= 1'b0;
      lockout_stb     <= 1'b0;
      id_enter_stb    <= 1'b0;
      id_exit_stb     <= 1'b0;
      cmd_addr        <= '0;
      cmd_data        <= '0;
    end else begin
      prog_stb        <= 1'b0;
      chip_erase_stb  <= 1'b0;
      block_erase_stb <= 1'b0;
      lockout_stb     <= 1'b0;
      id_enter_stb    <= 1'b0;
      id_exit_stb     <= 1'b0;
      if (evt_valid && !op_busy) begin
        st <= ST_IDLE;
        if (st == ST_PGM) begin
          if (!guard) begin
            prog_stb <= 1'b1;
            cmd_addr <= evt_addr;
            cmd_data <= evt_data;
          end
        end else if (evt_data == OP_ID_EXIT) begin
          id_exit_stb <= 1'b1;
          id_mode     <= 1'b0;
        end else begin
          unique case (st)
            ST_IDLE: if (at_a && evt_data == OP_UNLOCK_A) st <= ST_UNL1;
            ST_UNL1: if (at_b && evt_data == OP_UNLOCK_B) st <= ST_UNL2;
            ST_UNL2: begin
              if (at_a && evt_data == OP_PROGRAM) st <= ST_PGM;
              else if (at_a && evt_data == OP_ERASE) st <= ST_ER3;
              else if (at_a && evt_data == OP_ID_ENTER) begin
                id_enter_stb <= 1'b1;
                id_mode      <= 1'b1;
              end
            end
            ST_ER3: if (at_a && evt_data == OP_UNLOCK_A) st <= ST_ER4;
            ST_ER4: if (at_b && evt_data == OP_UNLOCK_B) st <= ST_ER5;
            ST_ER5: begin
              if (at_a && evt_data == OP_CHIP) chip_erase_stb <= 1'b1;
              else if (evt_data == OP_BLOCK) begin
                if (!guard) begin
                  block_erase_stb <= 1'b1;
                  cmd_addr        <= evt_addr;
                end
              end else if (at_a && evt_data == OP_LOCK) begin
                lockout_stb <= 1'b1;
                id_mode     <= 1'b1;
              end
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int BOOT_W   = 4,
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic              id_mode,
  input  logic              boot_locked,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DW-1:0]     array_rdata,
  output logic [DW-1:0]     rd_data
);
  localparam logic [DW-1:0] DEV_CODE = BOOT_TOP ? CODE_DEV_TOP : CODE_DEV_BOT;

  logic in_boot;
  logic unused_mid;
  logic [DW-1:0] id_val;

  assign in_boot = BOOT_TOP ? (&rd_addr[ADDR_W-1 -: BOOT_W])
                            : (~|rd_addr[ADDR_W-1 -: BOOT_W]);
  assign unused_mid = ^rd_addr[ADDR_W-BOOT_W-1:2];

  always_comb begin
    unique case (rd_addr[1:0])
      2'b00:   id_val = CODE_MFR;
      2'b01:   id_val = DEV_CODE;
      2'b10:   id_val = in_boot ? {{(DW-1){1'b0}}, boot_locked} : '0;
      default: id_val = '0;
    endcase
  end

  assign rd_data = id_mode ? id_val : array_rdata;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int CMP_W       = 11,
  parameter int BOOT_W      = 4,
  parameter bit BOOT_TOP    = 1'b0,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              op_busy,
  input  logic              boot_locked,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        array_rdata,
  output logic [7:0]        rd_data,
  output logic              id_mode,
  output logic              prog_stb,
  output logic              chip_erase_stb,
  output logic              block_erase_stb,
  output logic              lockout_stb,
  output logic              id_enter_stb,
  output logic              id_exit_stb,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);
  logic              evt_valid;
  logic [ADDR_W-1:0] evt_addr;
  logic [DW-1:0]     evt_data;

  fcd_bus_filter #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .MIN_PULSE(MIN_PULSE)
  ) u_filter (
    .clk(clk), .rst_n(rst_n),
    .ce_n(bus_ce_n), .we_n(bus_we_n), .oe_n(bus_oe_n),
    .addr(bus_addr), .wdata(bus_wdata),
    .evt_valid(evt_valid), .evt_addr(evt_addr), .evt_data(evt_data)
  );

  fcd_seq_fsm #(
    .ADDR_W(ADDR_W), .CMP_W(CMP_W), .BOOT_W(BOOT_W), .BOOT_TOP(BOOT_TOP)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_addr(evt_addr), .evt_data(evt_data),
    .op_busy(op_busy), .boot_locked(boot_locked),
    .id_mode(id_mode),
    .prog_stb(prog_stb), .chip_erase_stb(chip_erase_stb),
    .block_erase_stb(block_erase_stb), .lockout_stb(lockout_stb),
    .id_enter_stb(id_enter_stb), .id_exit_stb(id_exit_stb),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  fcd_read_mux #(
    .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .BOOT_TOP(BOOT_TOP)
  ) u_rmux (
    .id_mode(id_mode), .boot_locked(boot_locked),
    .rd_addr(rd_addr), .array_rdata(array_rdata), .rd_data(rd_data)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int ADDR_W   = 18,
  parameter int BOOT_W   = 4,
  parameter bit BOOT_TOP = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic [ADDR_W-1:0] evt_addr,
  input logic              op_busy,
  input logic              boot_locked,
  input logic              id_mode,
  input logic              prog_stb,
  input logic              chip_erase_stb,
  input logic              block_erase_stb,
  input logic              lockout_stb,
  input logic              id_enter_stb,
  input logic              id_exit_stb,
  input logic [ADDR_W-1:0] cmd_addr
);
  logic [5:0] stb;
  logic       cmd_in_boot;

  assign stb = {prog_stb, chip_erase_stb, block_erase_stb,
                lockout_stb, id_enter_stb, id_exit_stb};
  assign cmd_in_boot = BOOT_TOP ? (&cmd_addr[ADDR_W-1 -: BOOT_W])
                                : (~|cmd_addr[ADDR_W-1 -: BOOT_W]);

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));
  // R11
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb) |=> !(|stb));
  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && op_busy) |=> !(|stb));
  // R2
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb) |-> $past(evt_valid));
  // R2
  prog_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |-> (cmd_addr == $past(evt_addr)));
  // R4
  enter_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_enter_stb |-> id_mode);
  // R4
  exit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_exit_stb |-> !id_mode);
  // R5
  lock_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lockout_stb |-> id_mode);
  // R10
  boot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((prog_stb || block_erase_stb) && $past(boot_locked)) |-> !cmd_in_boot);
endmodule

bind flash_cmd_decoder fcd_checker #(
  .ADDR_W(ADDR_W), .BOOT_W(BOOT_W), .BOOT_TOP(BOOT_TOP)
) u_fcd_chk (
  .clk(clk), .rst_n(rst_n),
  .evt_valid(evt_valid), .evt_addr(evt_addr),
  .op_busy(op_busy), .boot_locked(boot_locked), .id_mode(id_mode),
  .prog_stb(prog_stb), .chip_erase_stb(chip_erase_stb),
  .block_erase_stb(block_erase_stb), .lockout_stb(lockout_stb),
  .id_enter_stb(id_enter_stb), .id_exit_stb(id_exit_stb),
  .cmd_addr(cmd_addr)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int AW = 18;
  // strobe kinds: 0 none, 1 program, 2 chip erase, 3 block erase, 4 lockout, 5 id enter, 6 id exit
  localparam int NV = 35;
  localparam logic [28:0] VEC [NV] = '{
    {18'h00555, 8'hAA, 3'd0}, {18'h002AA, 8'h55, 3'd0}, {18'h00555, 8'hA0, 3'd0},
    {18'h12345, 8'h3C, 3'd1},
    {18'h00555, 8'hAA, 3'd0}, {18'h002AA, 8'h55, 3'd0}, {18'h00555, 8'h80, 3'd0},
    {18'h00555, 8'hAA, 3'd0}, {18'h002AA, 8'h55, 3'd0}, {18'h00555, 8'h10, 3'd2},
    {18'h00555, 8'hAA, 3'd0}, {18'h002AA, 8'h55, 3'd0}, {18'h00555, 8'h80, 3'd0},
    {18'h00555, 8'hAA, 3'd0}, {18'h002AA, 8'h55, 3'd0}, {18'h28000, 8'h30, 3'd3},
    {18'h00555, 8'hAA, 3'd0}, {18'h002AA, 8'h55, 3'd0}, {18'h00555, 8'h90, 3'd5},
    {18'h3FFFF, 8'hF0, 3'd6},
    {18'h00555, 8'hAA, 3'd0}, {18'h002AA, 8'h56, 3'd0}, {18'h00555, 8'hA0, 3'd0},
    {18'h00100, 8'h77, 3'd0},
    {18'h01555, 8'hAA, 3'd0}, {18'h3A2AA, 8'h55, 3'd0}, {18'h00D55, 8'hA0, 3'd0},
    {18'h04000, 8'h5A, 3'd1},
    {18'h00555, 8'hAA, 3'd0}, {18'h002AA, 8'h55, 3'd0}, {18'h00555, 8'h80, 3'd0},
    {18'h00555, 8'hAA, 3'd0}, {18'h002AA, 8'h55, 3'd0}, {18'h00555, 8'h40, 3'd4},
    {18'h00000, 8'hF0, 3'd6}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
  logic [AW-1:0] bus_addr = '0, rd_addr = '0;
  logic [7:0] bus_wdata = '0, array_rdata = 8'hC3;
  logic op_busy = 1'b0, boot_locked = 1'b0;
  logic [7:0] rd_data, cmd_data;
  logic [AW-1:0] cmd_addr;
  logic id_mode, prog_stb, chip_erase_stb, block_erase_stb, lockout_stb;
  logic id_enter_stb, id_exit_stb;

  int checks = 0, errors = 0;
  int cnt [7];
  int snap [7];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n),
    .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .op_busy(op_busy), .boot_locked(boot_locked),
    .rd_addr(rd_addr), .array_rdata(array_rdata), .rd_data(rd_data),
    .id_mode(id_mode), .prog_stb(prog_stb), .chip_erase_stb(chip_erase_stb),
    .block_erase_stb(block_erase_stb), .lockout_stb(lockout_stb),
    .id_enter_stb(id_enter_stb), .id_exit_stb(id_exit_stb),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  initial for (int k = 0; k < 7; k++) cnt[k] = 0;

  always @(negedge clk) begin
    if (prog_stb)        cnt[1] = cnt[1] + 1;
    if (chip_erase_stb)  cnt[2] = cnt[2] + 1;
    if (block_erase_stb) cnt[3] = cnt[3] + 1;
    if (lockout_stb)     cnt[4] = cnt[4] + 1;
    if (id_enter_stb)    cnt[5] = cnt[5] + 1;
    if (id_exit_stb)     cnt[6] = cnt[6] + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic take_snap();
    for (int k = 0; k < 7; k++) snap[k] = cnt[k];
  endtask

  task automatic chk_kind(input int exp, input string req);
    int got, hits;
    got = 0;
    hits = 0;
    for (int k = 1; k < 7; k++) begin
      if (cnt[k] != snap[k]) begin
        hits += cnt[k] - snap[k];
        got = k;
      end
    end
    if (hits > 1) got = 7;
    chk(got == exp, req, got, exp);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input int len = 6, input bit oe_low = 1'b0);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_oe_n  = oe_low ? 1'b0 : 1'b1;
    bus_ce_n  = 1'b0;
    bus_we_n  = 1'b0;
    repeat (len) @(negedge clk);
    bus_we_n = 1'b1;
    bus_ce_n = 1'b1;
    @(negedge clk);
    bus_oe_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic unlock(input int len = 6);
    wr(18'h00555, 8'hAA, len);
    wr(18'h002AA, 8'h55, len);
  endtask

  task automatic erase_prefix();
    unlock();
    wr(18'h00555, 8'h80);
    unlock();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk({prog_stb, chip_erase_stb, block_erase_stb, lockout_stb, id_enter_stb, id_exit_stb} == 6'b0,
        "R11 strobes low after reset", 0, 0);
    chk(id_mode == 1'b0, "R11 id_mode after reset", int'(id_mode), 0);
    // R6 array passthrough
    chk(rd_data == 8'hC3, "R6 array read in array mode", int'(rd_data), 8'hC3);

    // table walk: R1 R2 R3 R4 R5 R7 R11
    for (int i = 0; i < NV; i++) begin
      take_snap();
      wr(VEC[i][28:11], VEC[i][10:3]);
      chk_kind(int'(VEC[i][2:0]), $sformatf("R1 R2 R3 R4 R7 vector %0d", i));
      if (VEC[i][2:0] == 3'd1) begin
        chk(cmd_addr == VEC[i][28:11], "R2 program address", int'(cmd_addr), int'(VEC[i][28:11]));
        chk(cmd_data == VEC[i][10:3], "R2 program data", int'(cmd_data), int'(VEC[i][10:3]));
      end
      if (VEC[i][2:0] == 3'd3)
        chk(cmd_addr == VEC[i][28:11], "R3 block address", int'(cmd_addr), int'(VEC[i][28:11]));
    end
    chk(id_mode == 1'b0, "R4 array mode after exit", int'(id_mode), 0);

    // R6 identification reads
    unlock();
    wr(18'h00555, 8'h90);
    chk(id_mode == 1'b1, "R4 id mode after entry", int'(id_mode), 1);
    @(negedge clk); rd_addr = 18'h00000; #1;
    chk(rd_data == 8'h9D, "R6 manufacturer code", int'(rd_data), 8'h9D);
    rd_addr = 18'h23401; #1;
    chk(rd_data == 8'h2D, "R6 device code bottom boot", int'(rd_data), 8'h2D);
    rd_addr = 18'h00FF2; boot_locked = 1'b0; #1;
    chk(rd_data == 8'h00, "R6 lock status clear", int'(rd_data), 0);
    boot_locked = 1'b1; #1;
    chk(rd_data == 8'h01, "R6 lock status set", int'(rd_data), 1);
    rd_addr = 18'h10002; #1;
    chk(rd_data == 8'h00, "R6 lock query outside boot block", int'(rd_data), 0);
    rd_addr = 18'h00003; #1;
    chk(rd_data == 8'h00, "R6 other offset", int'(rd_data), 0);
    boot_locked = 1'b0;
    take_snap();
    wr(18'h12345, 8'hF0);
    chk_kind(6, "R4 single exit write");
    @(negedge clk); rd_addr = 18'h00000; #1;
    chk(rd_data == 8'hC3, "R6 array read after exit", int'(rd_data), 8'hC3);

    // R5 lockout holds identification mode
    erase_prefix();
    take_snap();
    wr(18'h00555, 8'h40);
    chk_kind(4, "R5 lockout strobe");
    chk(id_mode == 1'b1, "R5 id mode after lockout", int'(id_mode), 1);
    #1;
    chk(rd_data == 8'h9D, "R5 reads not array after lockout", int'(rd_data), 8'h9D);
    wr(18'h00000, 8'hF0);
    chk(id_mode == 1'b0, "R5 array mode after exit", int'(id_mode), 0);

    // R10 boot protection
    boot_locked = 1'b1;
    unlock(); wr(18'h00555, 8'hA0);
    take_snap(); wr(18'h00010, 8'h12);
    chk_kind(0, "R10 program into locked boot dropped");
    erase_prefix();
    take_snap(); wr(18'h00000, 8'h30);
    chk_kind(0, "R10 block erase of locked boot dropped");
    erase_prefix();
    take_snap(); wr(18'h08000, 8'h30);
    chk_kind(3, "R10 block erase outside boot allowed");
    boot_locked = 1'b0;
    unlock(); wr(18'h00555, 8'hA0);
    take_snap(); wr(18'h00010, 8'h12);
    chk_kind(1, "R10 program into unlocked boot");

    // R8 busy keeps sequence position
    unlock(); wr(18'h00555, 8'hA0);
    op_busy = 1'b1;
    take_snap(); wr(18'h00200, 8'h99);
    chk_kind(0, "R8 write ignored while busy");
    op_busy = 1'b0;
    take_snap(); wr(18'h00201, 8'h98);
    chk_kind(1, "R8 armed program survives busy");
    chk(cmd_addr == 18'h00201, "R8 program address after busy", int'(cmd_addr), 18'h201);

    // R9 pulse filter
    unlock();
    wr(18'h00555, 8'hA0, 3);
    take_snap(); wr(18'h00300, 8'h11);
    chk_kind(0, "R9 three-cycle pulse rejected");
    unlock(4); wr(18'h00555, 8'hA0, 4);
    take_snap(); wr(18'h00301, 8'h22, 4);
    chk_kind(1, "R9 four-cycle pulse accepted");
    chk(cmd_data == 8'h22, "R9 data from write", int'(cmd_data), 8'h22);
    unlock(); wr(18'h00555, 8'hA0);
    take_snap(); wr(18'h00302, 8'h33, 6, 1'b1);
    chk_kind(0, "R9 write with output enable low inhibited");
    take_snap(); wr(18'h00303, 8'h44);
    chk_kind(1, "R9 program after inhibited write");

    // R4 exit mid sequence, F0 as program data
    wr(18'h00555, 8'hAA);
    take_snap(); wr(18'h00123, 8'hF0);
    chk_kind(6, "R4 exit in mid sequence");
    unlock(); wr(18'h00555, 8'hA0);
    take_snap(); wr(18'h00400, 8'hF0);
    chk_kind(1, "R4 F0 taken as program data");
    chk(cmd_data == 8'hF0, "R2 program data F0", int'(cmd_data), 8'hF0);

    done = 1'b1;
    finish_run();
  end
endmodule